// File: doc/BRIEF.md
# Call/Return Stack Controller

This block owns the hardware stack of a small processor core. It keeps a 16-bit stack pointer and moves single bytes between the core and a single-port byte-wide data memory. The stack grows toward lower addresses. A push stores the byte at the address the pointer holds and then moves the pointer down. A pop first moves the pointer up and then reads the byte at that address.

The core starts one operation at a time with `req_valid` and an operation code. The operations are byte push, byte pop, absolute call, relative call and return. A call stores the 24-bit return address as three bytes. A return reads three bytes back and rebuilds the program counter from them. While a sequence runs, `busy` is high and the block makes exactly one memory access per clock. `done` pulses for one cycle after the last access, and the cycle that carries `done` also presents the new program counter or the popped byte.

A small I/O window lets the core read and write the two halves of the stack pointer and an 8-bit status register. An access to any other I/O address raises an error flag.

The sequencer has seven states:
- S_IDLE waits for a request.
- S_WR_HI, S_WR_MID and S_WR_LO each write one byte, from the most significant byte down.
- S_RD_LO, S_RD_MID and S_RD_HI each read one byte, from the least significant byte up.

Its transitions are:
- S_IDLE goes to S_WR_LO for a push, to S_WR_HI for either kind of call, and to S_RD_LO for a pop or a return.
- The write states run S_WR_HI to S_WR_MID, S_WR_MID to S_WR_LO, and S_WR_LO back to S_IDLE.
- S_RD_LO goes back to S_IDLE for a pop and on to S_RD_MID for a return.
- S_RD_MID goes to S_RD_HI, and S_RD_HI goes back to S_IDLE.

Top module: `stk_ctrl`

## Requirements
- R1: After reset `busy`, `done`, `mem_we`, `mem_re` and `sreg_out` are 0, and the stack pointer equals the parameter RESET_SP.
- R2: Operation code 0 (push) writes `req_byte` to the address held in the stack pointer, then decrements the pointer by one.
- R3: Operation code 1 (pop) increments the stack pointer first, reads the byte at the new address, and presents that byte on `pop_byte` while `done` is high.
- R4: Operation code 2 (absolute call) sets the return address to `req_pc`+2. It writes bits 23:16, then 15:8, then 7:0 of the return address to SP, SP-1 and SP-2 in turn, and leaves SP reduced by 3. While `done` is high, `pc_out` equals `req_tgt`.
- R5: Operation code 3 (relative call) performs the same three writes as R4. While `done` is high, `pc_out` equals `req_pc` + `req_tgt` modulo 2^24, with `req_tgt` taken as a signed offset.
- R6: Operation code 4 (return) reads SP+1, SP+2 and SP+3 as the low, middle and high byte, and leaves SP increased by 3. While `done` is high, `pc_out` shows {high, middle, low}.
- R7: While `busy` is high, exactly one of `mem_we` and `mem_re` is high in each cycle, and both are low while `busy` is low. Push and pop keep `busy` high for 1 cycle, the three call and return operations for 3 cycles. `done` is a one-cycle pulse in the cycle after the last access.
- R8: An I/O write to address 0x3D replaces bits 7:0 of the stack pointer, and a write to 0x3E replaces bits 15:8. `io_rdata` returns those halves when `io_re` is high with the same addresses.
- R9: An I/O write to address 0x3F loads the status register. The status register appears on `sreg_out` and is read back through `io_rdata` at 0x3F.
- R10: `io_err` is high in any cycle where `io_we` or `io_re` is high with an address other than 0x3D, 0x3E or 0x3F. Such a write changes neither the stack pointer nor the status register.
- R11: The stack pointer wraps modulo 2^16 in both directions. A write at 0x0000 is followed by a write at 0xFFFF, and a read at 0xFFFF is followed by a read at 0x0000.
- R12: The block ignores a request while it is busy, and ignores an operation code above 4. It also ignores I/O writes in a cycle where it is busy or accepts a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start request, sampled while idle |
| req_op | input | 3 | Operation: 0 push, 1 pop, 2 call, 3 relative call, 4 return |
| req_pc | input | 24 | Program counter of the calling instruction |
| req_tgt | input | 24 | Absolute target, or signed offset for a relative call |
| req_byte | input | 8 | Byte to push |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse after the last access |
| pc_out | output | 24 | New program counter, valid with done after a call or return |
| pop_byte | output | 8 | Popped byte, valid with done after a pop |
| mem_we | output | 1 | Data memory write strobe |
| mem_re | output | 1 | Data memory read strobe |
| mem_addr | output | 16 | Data memory byte address |
| mem_wdata | output | 8 | Data memory write byte |
| mem_rdata | input | 8 | Data memory read byte, valid in the same cycle as the address |
| io_we | input | 1 | I/O write strobe |
| io_re | input | 1 | I/O read strobe |
| io_addr | input | 6 | I/O address |
| io_wdata | input | 8 | I/O write byte |
| io_rdata | output | 8 | I/O read byte |
| io_err | output | 1 | Unsupported I/O address |
| sreg_out | output | 8 | Status register |

## Verification
The bench builds the block with RESET_SP set to 0x0004, so the stack starts just above address zero. With that setting, a push, a call and a return all run against an ordinary pointer. After the pointer is moved to 0x0001 through the I/O window, a relative call crosses zero to 0xFFFF, and the matching return crosses back. This covers both wrap directions of R11 with few cycles. The default of 0x08FF still elaborates in the checker, because no assertion depends on the reset value.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int PC_W   = 24;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_PUSH  = 3'd0,
        OP_POP   = 3'd1,
        OP_CALL  = 3'd2,
        OP_RCALL = 3'd3,
        OP_RET   = 3'd4
    } stk_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR_HI,
        S_WR_MID,
        S_WR_LO,
        S_RD_LO,
        S_RD_MID,
        S_RD_HI
    } stk_state_e;
endpackage

// File: rtl/stk_io_dec.sv
module stk_io_dec #(
    parameter int          IO_AW = 6,
    parameter logic [5:0]  A_SPL = 6'h3D,
    parameter logic [5:0]  A_SPH = 6'h3E,
    parameter logic [5:0]  A_SR  = 6'h3F
) (
    input  logic [IO_AW-1:0] addr,
    input  logic             access,
    output logic             hit_lo,
    output logic             hit_hi,
    output logic             hit_sr,
    output logic             err
);
    always_comb begin
        hit_lo = (addr == IO_AW'(A_SPL));
        hit_hi = (addr == IO_AW'(A_SPH));
        hit_sr = (addr == IO_AW'(A_SR));
        err    = access && !(hit_lo || hit_hi || hit_sr);
    end
endmodule

// File: rtl/stk_sp.sv
module stk_sp #(
    parameter int               SP_W     = 16,
    parameter logic [SP_W-1:0]  RESET_SP = 16'h08FF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc,
    input  logic            dec,
    input  logic            ld_lo,
    input  logic            ld_hi,
    input  logic [7:0]      ld_byte,
    output logic [SP_W-1:0] sp
);
    localparam int HI_W = SP_W - 8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp <= RESET_SP;
        end else if (inc) begin
            sp <= sp + 1'b1;
        end else if (dec) begin
            sp <= sp - 1'b1;
        end else if (ld_lo) begin
            sp[7:0] <= ld_byte;
        end else if (ld_hi) begin
            sp[SP_W-1:8] <= ld_byte[HI_W-1:0];
        end
    end
endmodule

// File: rtl/stk_fsm.sv
module stk_fsm
    import stk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [BYTE_W-1:0] push_byte,
    input  logic [PC_W-1:0]   ret_addr,
    input  logic [PC_W-1:0]   dest,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              busy,
    output logic              accept,
    output logic              acc_we,
    output logic              acc_re,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              done,
    output logic [PC_W-1:0]   pc_out,
    output logic [BYTE_W-1:0] pop_byte
);
    stk_state_e            state, state_nx;
    stk_op_e               op_q;
    logic [PC_W-1:0]       wbuf, dest_q;
    logic [2*BYTE_W-1:0]   rbuf;
    logic                  op_ok;

    assign op_ok  = (op <= 3'(OP_RET));
    assign accept = (state == S_IDLE) && start && op_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (accept) begin
                unique case (stk_op_e'(op))
                    OP_PUSH:          state_nx = S_WR_LO;
                    OP_CALL, OP_RCALL: state_nx = S_WR_HI;
                    default:          state_nx = S_RD_LO;
                endcase
            end
            S_WR_HI:  state_nx = S_WR_MID;
            S_WR_MID: state_nx = S_WR_LO;
            S_WR_LO:  state_nx = S_IDLE;
            S_RD_LO:  state_nx = (op_q == OP_RET) ? S_RD_MID : S_IDLE;
            S_RD_MID: state_nx = S_RD_HI;
            S_RD_HI:  state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // per-state outputs
    always_comb begin
        busy    = 1'b1;
        acc_we  = 1'b0;
        acc_re  = 1'b0;
        wr_byte = '0;
        unique case (state)
            S_IDLE:   busy = 1'b0;
            S_WR_HI:  begin acc_we = 1'b1; wr_byte = wbuf[23:16]; end
            S_WR_MID: begin acc_we = 1'b1; wr_byte = wbuf[15:8];  end
            S_WR_LO:  begin acc_we = 1'b1; wr_byte = wbuf[7:0];   end
            S_RD_LO, S_RD_MID, S_RD_HI: acc_re = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    // operand and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_PUSH;
            wbuf     <= '0;
            dest_q   <= '0;
            rbuf     <= '0;
            done     <= 1'b0;
            pc_out   <= '0;
            pop_byte <= '0;
        end else begin
            done <= (state == S_WR_LO) || (state == S_RD_HI) ||
                    (state == S_RD_LO && op_q == OP_POP);
            if (accept) begin
                op_q   <= stk_op_e'(op);
                wbuf   <= (stk_op_e'(op) == OP_PUSH) ? {16'h0, push_byte} : ret_addr;
                dest_q <= dest;
            end
            if (state == S_WR_LO && op_q != OP_PUSH) pc_out <= dest_q;
            if (state == S_RD_LO) begin
                rbuf[7:0] <= rd_byte;
                if (op_q == OP_POP) pop_byte <= rd_byte;
            end
            if (state == S_RD_MID) rbuf[15:8] <= rd_byte;
            if (state == S_RD_HI)  pc_out <= {rd_byte, rbuf};
        end
    end
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int               SP_W     = 16,
    parameter int               IO_AW    = 6,
    parameter logic [SP_W-1:0]  RESET_SP = 16'h08FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [PC_W-1:0]   req_pc,
    input  logic [PC_W-1:0]   req_tgt,
    input  logic [BYTE_W-1:0] req_byte,
    output logic              busy,
    output logic              done,
    output logic [PC_W-1:0]   pc_out,
    output logic [BYTE_W-1:0] pop_byte,
    output logic              mem_we,
    output logic              mem_re,
    output logic [SP_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              io_we,
    input  logic              io_re,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [BYTE_W-1:0] io_wdata,
    output logic [BYTE_W-1:0] io_rdata,
    output logic              io_err,
    output logic [BYTE_W-1:0] sreg_out
);
    localparam int HI_W = SP_W - 8;

    logic [SP_W-1:0] sp;
    logic            accept, io_ok;
    logic            hit_lo, hit_hi, hit_sr;
    logic [PC_W-1:0] ret_addr, dest;

    assign ret_addr = req_pc + PC_W'(2);
    assign dest     = (req_op == 3'(OP_RCALL)) ? req_pc + req_tgt : req_tgt;
    assign io_ok    = io_we && !busy && !accept;
    assign mem_addr = mem_re ? sp + 1'b1 : sp;

    stk_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(req_valid), .op(req_op),
        .push_byte(req_byte), .ret_addr(ret_addr), .dest(dest),
        .rd_byte(mem_rdata), .busy(busy), .accept(accept),
        .acc_we(mem_we), .acc_re(mem_re), .wr_byte(mem_wdata),
        .done(done), .pc_out(pc_out), .pop_byte(pop_byte)
    );

    stk_io_dec #(.IO_AW(IO_AW)) u_dec (
        .addr(io_addr), .access(io_we || io_re),
        .hit_lo(hit_lo), .hit_hi(hit_hi), .hit_sr(hit_sr), .err(io_err)
    );

    stk_sp #(.SP_W(SP_W), .RESET_SP(RESET_SP)) u_sp (
        .clk(clk), .rst_n(rst_n), .inc(mem_re), .dec(mem_we),
        .ld_lo(io_ok && hit_lo), .ld_hi(io_ok && hit_hi),
        .ld_byte(io_wdata), .sp(sp)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                sreg_out <= '0;
        else if (io_ok && hit_sr)  sreg_out <= io_wdata;
    end

    always_comb begin
        io_rdata = '0;
        if (hit_lo)      io_rdata = sp[7:0];
        else if (hit_hi) io_rdata = BYTE_W'(sp[SP_W-1:8]);
        else if (hit_sr) io_rdata = sreg_out;
    end
endmodule

// File: rtl/stk_ctrl_chk.sv
module stk_ctrl_chk #(
    parameter int SP_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            mem_we,
    input logic            mem_re,
    input logic [SP_W-1:0] mem_addr,
    input logic [SP_W-1:0] sp
);
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mem_we ^ mem_re)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_we || mem_re)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy)); // R7
    AST_WR_AT_SP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == sp)); // R2
    AST_RD_ABOVE_SP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (mem_addr == SP_W'(sp + 1'b1))); // R3
    AST_WR_DEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp == SP_W'($past(sp) - 1'b1))); // R11
    AST_RD_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (sp == SP_W'($past(sp) + 1'b1))); // R11
endmodule

bind stk_ctrl stk_ctrl_chk #(.SP_W(SP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .sp(sp)
);

// File: tb/stk_ctrl_tb.sv
module stk_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [23:0] req_pc = '0, req_tgt = '0;
    logic [7:0]  req_byte = '0;
    logic        busy, done, mem_we, mem_re, io_err;
    logic [23:0] pc_out;
    logic [7:0]  pop_byte, mem_wdata, mem_rdata, io_rdata, sreg_out;
    logic [15:0] mem_addr;
    logic        io_we = 1'b0, io_re = 1'b0;
    logic [5:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;

    logic [7:0]  bmem [256];
    logic [15:0] lg_a [8];
    logic        lg_w [8];
    logic [7:0]  lg_d [8];
    int          lg_n = 0;
    int          n_chk = 0, n_err = 0;
    bit          finished = 0;

    always #2 clk = ~clk;

    stk_ctrl #(.RESET_SP(16'h0004)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_pc(req_pc), .req_tgt(req_tgt), .req_byte(req_byte),
        .busy(busy), .done(done), .pc_out(pc_out), .pop_byte(pop_byte),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .io_we(io_we), .io_re(io_re), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_err(io_err), .sreg_out(sreg_out)
    );

    assign mem_rdata = bmem[mem_addr[7:0]];

    initial for (int i = 0; i < 256; i++) bmem[i] = 8'h00;

    always @(posedge clk) begin
        if (rst_n && (mem_we || mem_re)) begin
            if (lg_n < 8) begin
                lg_a[lg_n] = mem_addr;
                lg_w[lg_n] = mem_we;
                lg_d[lg_n] = mem_we ? mem_wdata : mem_rdata;
            end
            lg_n = lg_n + 1;
            if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic io_rd(input logic [5:0] a, output logic [7:0] v);
        io_addr = a; io_re = 1'b1; #1;
        v = io_rdata; io_re = 1'b0;
    endtask

    task automatic get_sp(output logic [15:0] v);
        logic [7:0] lo, hi;
        io_rd(6'h3D, lo);
        io_rd(6'h3E, hi);
        v = {hi, lo};
    endtask

    task automatic io_wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_we = 1'b1;
        @(negedge clk);
        io_we = 1'b0;
    endtask

    task automatic set_sp(input logic [15:0] v);
        io_wr(6'h3E, v[15:8]);
        io_wr(6'h3D, v[7:0]);
    endtask

    task automatic run_op(input logic [2:0] op, input logic [23:0] pc, input logic [23:0] tgt,
                          input logic [7:0] b, output int n);
        @(negedge clk);
        lg_n = 0;
        req_op = op; req_pc = pc; req_tgt = tgt; req_byte = b; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (busy && n < 16) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [15:0] s;
        chk(!busy && !done, "R1 idle after reset", {busy, done}, 0);
        chk(!mem_we && !mem_re, "R1 no access after reset", {mem_we, mem_re}, 0);
        chk(sreg_out == 8'h00, "R1 status reset", sreg_out, 0);
        get_sp(s);
        chk(s == 16'h0004, "R1 pointer reset", s, 16'h0004);
    endtask

    task automatic t_push_pop;
        int n; logic [15:0] s;
        run_op(3'd0, 0, 0, 8'hA5, n);
        chk(n == 1, "R7 push length", n, 1);
        chk(done, "R7 push done", done, 1);
        chk(lg_n == 1 && lg_w[0] && lg_a[0] == 16'h0004 && lg_d[0] == 8'hA5,
            "R2 push write", {lg_a[0], lg_d[0]}, {16'h0004, 8'hA5});
        get_sp(s);
        chk(s == 16'h0003, "R2 push decrements", s, 16'h0003);
        @(negedge clk);
        chk(!done, "R7 done one cycle", done, 0);
        run_op(3'd1, 0, 0, 0, n);
        chk(n == 1, "R7 pop length", n, 1);
        chk(lg_n == 1 && !lg_w[0] && lg_a[0] == 16'h0004, "R3 pop address", lg_a[0], 16'h0004);
        chk(done && pop_byte == 8'hA5, "R3 pop data", pop_byte, 8'hA5);
        get_sp(s);
        chk(s == 16'h0004, "R3 pop increments", s, 16'h0004);
    endtask

    task automatic t_call_ret;
        int n; logic [15:0] s;
        run_op(3'd2, 24'h123456, 24'h00ABCD, 0, n);
        chk(n == 3, "R7 call length", n, 3);
        chk(lg_n == 3 && lg_a[0] == 16'h0004 && lg_a[1] == 16'h0003 && lg_a[2] == 16'h0002,
            "R4 call addresses", {lg_a[0][7:0], lg_a[1][7:0], lg_a[2][7:0]}, 24'h040302);
        chk(lg_d[0] == 8'h12 && lg_d[1] == 8'h34 && lg_d[2] == 8'h58,
            "R4 call bytes high first", {lg_d[0], lg_d[1], lg_d[2]}, 24'h123458);
        chk(done && pc_out == 24'h00ABCD, "R4 call target", pc_out, 24'h00ABCD);
        get_sp(s);
        chk(s == 16'h0001, "R4 call pointer", s, 16'h0001);
        run_op(3'd4, 0, 0, 0, n);
        chk(n == 3, "R7 return length", n, 3);
        chk(lg_n == 3 && lg_a[0] == 16'h0002 && lg_a[1] == 16'h0003 && lg_a[2] == 16'h0004,
            "R6 return addresses", {lg_a[0][7:0], lg_a[1][7:0], lg_a[2][7:0]}, 24'h020304);
        chk(done && pc_out == 24'h123458, "R6 return pc", pc_out, 24'h123458);
        get_sp(s);
        chk(s == 16'h0004, "R6 return pointer", s, 16'h0004);
    endtask

    task automatic t_rcall_wrap;
        int n; logic [15:0] s;
        set_sp(16'h0001);
        run_op(3'd3, 24'h000010, 24'hFFFFF0, 0, n);
        chk(done && pc_out == 24'h000000, "R5 relative target", pc_out, 0);
        chk(lg_n == 3 && lg_a[1] == 16'h0000 && lg_a[2] == 16'hFFFF,
            "R11 write wraps below zero", lg_a[2], 16'hFFFF);
        chk(lg_d[2] == 8'h12 && lg_d[0] == 8'h00, "R5 return address bytes", lg_d[2], 8'h12);
        get_sp(s);
        chk(s == 16'hFFFE, "R11 pointer after wrap", s, 16'hFFFE);
        run_op(3'd4, 0, 0, 0, n);
        chk(lg_n == 3 && lg_a[0] == 16'hFFFF && lg_a[1] == 16'h0000,
            "R11 read wraps above top", lg_a[1], 16'h0000);
        chk(done && pc_out == 24'h000012, "R6 return across wrap", pc_out, 24'h000012);
        get_sp(s);
        chk(s == 16'h0001, "R11 pointer back", s, 16'h0001);
    endtask

    task automatic t_io_regs;
        logic [15:0] s; logic [7:0] v;
        set_sp(16'h1234);
        get_sp(s);
        chk(s == 16'h1234, "R8 pointer halves", s, 16'h1234);
        io_wr(6'h3F, 8'h5A);
        chk(sreg_out == 8'h5A, "R9 status write", sreg_out, 8'h5A);
        io_rd(6'h3F, v);
        chk(v == 8'h5A, "R9 status read", v, 8'h5A);
        io_rd(6'h3D, v);
        chk(!io_err, "R10 no error on valid address", io_err, 0);
    endtask

    task automatic t_io_bad;
        logic [15:0] s; logic e;
        @(negedge clk);
        io_addr = 6'h20; io_wdata = 8'h77; io_we = 1'b1; #1;
        e = io_err;
        @(negedge clk);
        io_we = 1'b0;
        chk(e, "R10 error flag", e, 1);
        get_sp(s);
        chk(s == 16'h1234, "R10 pointer untouched", s, 16'h1234);
        chk(sreg_out == 8'h5A, "R10 status untouched", sreg_out, 8'h5A);
    endtask

    task automatic t_busy_ignore;
        logic [15:0] s; int n;
        set_sp(16'h0010);
        @(negedge clk);
        lg_n = 0;
        req_op = 3'd2; req_pc = 0; req_tgt = 24'h40; req_valid = 1'b1;
        @(negedge clk);
        req_op = 3'd0; io_addr = 6'h3D; io_wdata = 8'h99; io_we = 1'b1;
        n = 0;
        while (busy && n < 16) begin n++; @(negedge clk); end
        req_valid = 1'b0; io_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(lg_n == 3 && !busy, "R12 request during busy ignored", lg_n, 3);
        get_sp(s);
        chk(s == 16'h000D, "R12 io write during busy ignored", s, 16'h000D);
        @(negedge clk);
        lg_n = 0;
        req_op = 3'd7; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!busy && lg_n == 0, "R12 unknown op ignored", busy, 0);
        get_sp(s);
        chk(s == 16'h000D, "R12 pointer after unknown op", s, 16'h000D);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_push_pop();
        t_call_ret();
        t_rcall_wrap();
        t_io_regs();
        t_io_bad();
        t_busy_ignore();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule